// File: doc/BRIEF.md
# Major-Cycle Sequencer with Step-Timed Memory Strobes

This block is the control sequencer of a small processor. A 2-bit cycle code shows which major cycle is running: fetch, indirect, execute or interrupt. Each major cycle is made of one or more machine cycles. Every machine cycle has four timing steps. The sequencer drives a 10-bit memory address from its address register and raises a read or a write strobe during the middle two steps. At the close of the last step of the last machine cycle it chooses the next major cycle. That choice uses the addressing-mode flag from the decoder and the pending, enabled interrupt request.

The datapath covers only what one sample instruction needs. Increment-and-skip-if-zero reads its operand in one machine cycle and writes back the operand plus one in a second. If the new value is zero, the next instruction is skipped. All other opcodes execute as one machine cycle without memory traffic. The interrupt cycle saves the program counter to a fixed location and restarts at a fixed vector.

The memory side is a strobe-timed bus, not a valid/ready stream. Memory gets no back-pressure: read data must be valid on `mem_rdata` before the rising edge that closes step 3. A write presents its data from step 1 of its machine cycle until step 4.

Top module: `icc_sequencer`

## Requirements
- R1: While reset is held, the cycle code is 00 (fetch), the address is 0, and both strobes are low. The first fetch after reset reads address 0.
- R2: Every machine cycle lasts exactly four clocks (steps 1 to 4). The address is valid from step 1 and holds through step 4. A strobe is high only in steps 2 and 3. A fetch reads at the program counter.
- R3: At the end of a fetch, the indirect flag sampled on the edge that closes step 4 selects the next code: 01 (indirect) when high, 10 (execute) when low.
- R4: An indirect cycle is always followed by execute (10). It reads the instruction's address field (bits 9:0), and the low 10 bits of the word read become the operand address.
- R5: At the end of an execute, the code becomes 11 (interrupt) if request and enable are both high on the edge that closes step 4. Otherwise it becomes 00 (fetch).
- R6: An interrupt cycle is always followed by fetch. It writes the zero-extended program counter to address 0, and the next fetch reads address 1.
- R7: The cycle code changes only on the edge that closes step 4 of the last machine cycle of a major cycle.
- R8: Opcode 2 in instruction bits 15:12 is increment-and-skip-if-zero. It reads the operand in a first machine cycle, then writes operand+1 (modulo 2^16) to the same address in a second. The write data is valid in all four steps of the write machine cycle.
- R9: When that incremented value is zero, the program counter advances by one more, so the next fetch skips one word.
- R10: Any other opcode executes as a single machine cycle with no strobe.
- R11: Read and write are never high together. `mem_wdata` is zero outside a write machine cycle.
- R12: The program counter advances by one after each fetch and wraps from 1023 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ind_flag | input | 1 | Decoder flag: current instruction uses indirect addressing |
| irq_req | input | 1 | Interrupt request |
| irq_en | input | 1 | Interrupt enable |
| mem_rdata | input | 16 | Data bus from memory |
| icc | output | 2 | Current cycle code (00 fetch, 01 indirect, 10 execute, 11 interrupt) |
| mem_addr | output | 10 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Data bus to memory |

## Verification
All outputs decode from registered state. A change of major cycle, a new address and the end of a write are therefore visible in the first clock after the edge that closes step 4, and a strobe rises one clock after step 1 begins. Inputs are sampled only on the edge that closes step 4, and read data is taken on the edge that closes step 3. The bench's reference model walks machine cycles four clocks at a time and samples the decoder flag and the interrupt inputs on that same closing edge. It compares every output at the falling edge of every clock, half a period away from the edge where state moves.

// File: rtl/icc_pkg.sv
package icc_pkg;
  typedef enum logic [1:0] {
    ICC_FETCH = 2'b00,
    ICC_INDIR = 2'b01,
    ICC_EXEC  = 2'b10,
    ICC_INTR  = 2'b11
  } icc_e;

  localparam int MC_STEPS = 4;
  localparam int STEP_W   = $clog2(MC_STEPS);
endpackage

// File: rtl/icc_step_timer.sv
module icc_step_timer #(
  parameter int N_STEPS = icc_pkg::MC_STEPS,
  localparam int SW = $clog2(N_STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] step,
  output logic          step_latch,
  output logic          step_end
);
  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (step_end)   cnt_q <= '0;
    else                 cnt_q <= cnt_q + SW'(1);
  end

  assign step       = cnt_q;
  assign step_latch = (cnt_q == SW'(N_STEPS - 2));
  assign step_end   = (cnt_q == SW'(N_STEPS - 1));

  // R2: the step count restarts at step 1 after the last step
  a_r2_step_restart: assert property (@(posedge clk) disable iff (!rst_n)
    step_end |=> (step == '0));
endmodule

// File: rtl/icc_next_sel.sv
module icc_next_sel
  import icc_pkg::*;
(
  input  icc_e cur,
  input  logic ind_flag,
  input  logic irq_pend,
  output icc_e nxt
);
  always_comb begin
    unique case (cur)
      ICC_FETCH: nxt = ind_flag ? ICC_INDIR : ICC_EXEC;
      ICC_INDIR: nxt = ICC_EXEC;
      ICC_EXEC:  nxt = irq_pend ? ICC_INTR : ICC_FETCH;
      default:   nxt = ICC_FETCH;
    endcase
  end
endmodule

// File: rtl/icc_strobe_gen.sv
module icc_strobe_gen #(
  parameter int N_STEPS = icc_pkg::MC_STEPS,
  localparam int SW = $clog2(N_STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] step,
  input  logic          rd_cyc,
  input  logic          wr_cyc,
  output logic          mem_rd,
  output logic          mem_wr
);
  logic mid_step;

  assign mid_step = (step != '0) && (step != SW'(N_STEPS - 1));
  assign mem_rd   = mid_step && rd_cyc && !wr_cyc;
  assign mem_wr   = mid_step && wr_cyc;

  // R11: read and write strobes are mutually exclusive
  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R2: no strobe in the first step of a machine cycle
  a_r2_quiet_first: assert property (@(posedge clk) disable iff (!rst_n)
    (step == '0) |-> !(mem_rd || mem_wr));
endmodule

// File: rtl/icc_sequencer.sv
module icc_sequencer
  import icc_pkg::*;
#(
  parameter int AW        = 10,
  parameter int DW        = 16,
  parameter int OPW       = 4,
  parameter int ISZ_OP    = 2,
  parameter int SAVE_ADDR = 0,
  parameter int VEC_ADDR  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ind_flag,
  input  logic          irq_req,
  input  logic          irq_en,
  input  logic [DW-1:0] mem_rdata,
  output logic [1:0]    icc,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata
);
  localparam int SW = STEP_W;

  icc_e          icc_q, icc_n;
  logic [SW-1:0] step;
  logic          step_latch, step_end;
  logic          mc_q;
  logic [AW-1:0] pc_q, mar_q;
  logic [DW-1:0] ir_q, mbr_q;
  logic          is_isz, rd_cyc, wr_cyc, last_mc, skip, irq_pend;
  logic [AW-1:0] pc_after;

  icc_step_timer #(.N_STEPS(MC_STEPS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .step_latch (step_latch),
    .step_end   (step_end)
  );

  assign irq_pend = irq_req && irq_en;

  icc_next_sel u_next (
    .cur      (icc_q),
    .ind_flag (ind_flag),
    .irq_pend (irq_pend),
    .nxt      (icc_n)
  );

  assign is_isz   = (ir_q[DW-1 -: OPW] == OPW'(ISZ_OP));
  assign rd_cyc   = (icc_q == ICC_FETCH) || (icc_q == ICC_INDIR) ||
                    ((icc_q == ICC_EXEC) && is_isz && !mc_q);
  assign wr_cyc   = (icc_q == ICC_INTR) ||
                    ((icc_q == ICC_EXEC) && is_isz && mc_q);
  assign last_mc  = !((icc_q == ICC_EXEC) && is_isz && !mc_q);
  assign skip     = (icc_q == ICC_EXEC) && is_isz && (mbr_q == '0);
  assign pc_after = pc_q + AW'(skip);

  icc_strobe_gen #(.N_STEPS(MC_STEPS)) u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .rd_cyc (rd_cyc),
    .wr_cyc (wr_cyc),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icc_q <= ICC_FETCH;
      mc_q  <= 1'b0;
      pc_q  <= '0;
      mar_q <= '0;
      ir_q  <= '0;
      mbr_q <= '0;
    end else begin
      if (step_latch && rd_cyc) begin
        unique case (icc_q)
          ICC_FETCH: ir_q  <= mem_rdata;
          ICC_EXEC:  mbr_q <= mem_rdata + DW'(1);
          default:   mbr_q <= mem_rdata;
        endcase
      end
      if (step_end) begin
        if (!last_mc) begin
          mc_q <= 1'b1;
        end else begin
          mc_q  <= 1'b0;
          icc_q <= icc_n;
          unique case (icc_q)
            ICC_FETCH: begin
              pc_q  <= pc_q + AW'(1);
              mar_q <= ir_q[AW-1:0];
            end
            ICC_INDIR: mar_q <= mbr_q[AW-1:0];
            ICC_EXEC: begin
              pc_q  <= pc_after;
              mar_q <= (icc_n == ICC_INTR) ? AW'(SAVE_ADDR) : pc_after;
            end
            default: begin
              pc_q  <= AW'(VEC_ADDR);
              mar_q <= AW'(VEC_ADDR);
            end
          endcase
        end
      end
    end
  end

  assign icc       = icc_q;
  assign mem_addr  = mar_q;
  assign mem_wdata = !wr_cyc ? '0 :
                     (icc_q == ICC_INTR) ? DW'(pc_q) : mbr_q;

  // R7: the cycle code holds except on the closing step
  a_r7_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !step_end |=> $stable(icc));
  // R2: the address holds across a machine cycle
  a_r2_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !step_end |=> $stable(mem_addr));
  // R4: indirect is left only for execute
  a_r4_indir_to_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (icc == 2'b01) |=> (icc == 2'b01 || icc == 2'b10));
  // R6: interrupt is left only for fetch
  a_r6_intr_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (icc == 2'b11) |=> (icc == 2'b11 || icc == 2'b00));
  // R11: write data is zero while no write machine cycle runs
  a_r11_wdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_wdata == '0));
endmodule

// File: tb/icc_sequencer_tb_top.sv
module icc_sequencer_tb_top;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ind_flag = 1'b0;
  logic          irq_req = 1'b0;
  logic          irq_en = 1'b0;
  logic [DW-1:0] mem_rdata;
  logic [1:0]    icc;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata;

  always #2 clk = ~clk;

  icc_sequencer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ind_flag  (ind_flag),
    .irq_req   (irq_req),
    .irq_en    (irq_en),
    .mem_rdata (mem_rdata),
    .icc       (icc),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata)
  );

  logic [DW-1:0] dmem [0:NW-1];
  logic [DW-1:0] mmem [0:NW-1];

  assign mem_rdata = mem_rd ? dmem[mem_addr] : '0;
  always @(posedge clk) if (mem_wr) dmem[mem_addr] <= mem_wdata;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_instr = 0, n_skip = 0, n_wrap = 0, n_ind = 0, n_int = 0;
  bit s_ind, s_irq;
  int m_pc, m_ea, m_v;
  logic [DW-1:0] m_ir;
  string ctag, ftag;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    ind_flag <= (cyc % 5) < 2;
    irq_req  <= (cyc > 2000) && (cyc < 6000) && ((cyc % 97) < 30);
    irq_en   <= (cyc % 53) < 40;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // one machine cycle: four clocks, compared at each falling edge
  task automatic mcycle(input logic [1:0] e_icc, input string icc_tag,
                        input int e_addr, input string a_tag,
                        input bit e_rd, input bit e_wr, input int e_wd,
                        input string s_tag);
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      chk(icc == e_icc, (s == 0) ? icc_tag : "R7", "icc", icc, e_icc);
      chk(mem_addr == AW'(e_addr), a_tag, "addr", mem_addr, e_addr);
      chk(mem_rd == (e_rd && (s == 1 || s == 2)), s_tag, "rd", mem_rd,
          e_rd && (s == 1 || s == 2));
      chk(mem_wr == (e_wr && (s == 1 || s == 2)), s_tag, "wr", mem_wr,
          e_wr && (s == 1 || s == 2));
      chk(mem_wdata == (e_wr ? DW'(e_wd) : DW'(0)), e_wr ? s_tag : "R11",
          "wdata", mem_wdata, e_wr ? DW'(e_wd) : DW'(0));
      chk(!(mem_rd && mem_wr), "R11", "overlap", mem_rd && mem_wr, 0);
      @(posedge clk);
      if (s == 3) begin
        s_ind = ind_flag;
        s_irq = irq_req && irq_en;
      end
    end
  endtask

  initial begin : model
    wait (rst_n);
    m_pc = 0;
    ctag = "R1";
    ftag = "R1";
    forever begin
      mcycle(2'b00, ctag, m_pc, ftag, 1'b1, 1'b0, 0, "R2");
      m_ir = mmem[m_pc];
      n_instr++;
      if (m_pc == NW - 1) n_wrap++;
      m_pc = (m_pc + 1) % NW;
      ftag = "R12";
      m_ea = int'(m_ir[AW-1:0]);
      if (s_ind) begin
        n_ind++;
        mcycle(2'b01, "R3", m_ea, "R4", 1'b1, 1'b0, 0, "R4");
        m_ea = int'(mmem[m_ea][AW-1:0]);
        ctag = "R4";
      end else begin
        ctag = "R3";
      end
      if (m_ir[15:12] == 4'h2) begin
        mcycle(2'b10, ctag, m_ea, "R8", 1'b1, 1'b0, 0, "R8");
        m_v = (int'(mmem[m_ea]) + 1) & 16'hFFFF;
        mcycle(2'b10, "R7", m_ea, "R8", 1'b0, 1'b1, m_v, "R8");
        mmem[m_ea] = DW'(m_v);
        if (m_v == 0) begin
          m_pc = (m_pc + 1) % NW;
          n_skip++;
          ftag = "R9";
        end
      end else begin
        mcycle(2'b10, ctag, m_ea, "R10", 1'b0, 1'b0, 0, "R10");
      end
      if (s_irq) begin
        n_int++;
        mcycle(2'b11, "R5", 0, "R6", 1'b0, 1'b1, m_pc, "R6");
        mmem[0] = DW'(m_pc);
        m_pc = 1;
        ctag = "R6";
      end else begin
        ctag = "R5";
      end
    end
  end

  initial begin : main
    for (int i = 0; i < NW; i++) begin
      logic [DW-1:0] w;
      if (i % 11 == 0)
        w = 16'hFFFF;
      else if (i % 3 == 0)
        w = {4'h2, 2'b00, (i % 9 == 0) ? AW'(((i * 5) % 93) * 11)
                                       : AW'((i * 37 + 5) % NW)};
      else
        w = {4'((i * 7 + 1) % 16), 2'b01, AW'((i * 53 + 9) % NW)};
      dmem[i] = w;
      mmem[i] = w;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(icc == 2'b00, "R1", "reset icc", icc, 0);
    chk(mem_addr == '0, "R1", "reset addr", mem_addr, 0);
    chk(!mem_rd && !mem_wr, "R1", "reset strobes", {mem_rd, mem_wr}, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    wait (n_instr >= 2200);
    chk(n_ind > 0, "R3", "indirect cycles seen", n_ind, 1);
    chk(n_int > 0, "R6", "interrupt cycles seen", n_int, 1);
    chk(n_skip > 0, "R9", "skips seen", n_skip, 1);
    chk(n_wrap > 0, "R12", "pc wraps seen", n_wrap, 1);
    summary();
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d instructions expected 2200", n_instr);
    summary();
    $finish;
  end
endmodule